// File: doc/BRIEF.md
# Four-Times Oversampling Interpolator with Error-Feedback Requantizer

This block sits between a multichannel audio datapath and a set of current-output converters. It accepts one 18-bit two's complement sample per channel in each input frame. A single shared datapath, stepped across the channels one per clock, produces four interpolated output values per frame for every channel. Each value passes through a first-order error-feedback requantizer that shortens it to a 14-bit sign-magnitude converter code.

The output rate is four times the input frame rate. No faster reference clock is needed. The block counts system clocks between successive frame strobes and divides that count by four to place the four output updates inside each frame. Until one full frame period has been measured, the outputs stay at zero and no output strobe is issued. Linear interpolation between consecutive input frames keeps the passband out to half the input rate and suppresses the images around multiples of the input rate.

Top module: `os4_shaper`

## Requirements
- R1: After reset every channel code is zero and `os_tick` is low. No code changes and no `os_tick` pulse occur before the second `frame_tick`, because before then no frame period has been measured.
- R2: From the second `frame_tick` onward, each `frame_tick` starts four one-cycle `os_tick` pulses. They come NCH+1, NCH+1+Q, NCH+1+2Q and NCH+1+3Q cycles after the `frame_tick` cycle, where Q = floor(P/4) and P is the number of clocks since the previous `frame_tick`. At each pulse, the codes of all channels already hold the new values. This holds when the frame is longer than 3Q+NCH+1 cycles.
- R3: For output phase k (0 to 3), the interpolated value of a channel is floor((A·(4−k) + B·k + 2)/4). A is the value that channel latched at the previous `frame_tick`, and B is the value it latched at the current one.
- R4: Each channel keeps its own 4-bit remainder e, which is zero after reset. The interpolated value plus e forms a sum S. The code value is floor(S/16), and the new e is S − 16·floor(S/16).
- R5: A sum S above 131071 is clipped to 131071 before the division. The result is positive full scale (code 0x1FFF), never a wrapped negative value.
- R6: Channel c occupies `dac_codes[14c+13:14c]`. Bit 13 is the sign (1 means negative) and bits 12:0 are the magnitude. Zero is always coded with sign 0. The value −8192 is coded as 0x3FFF, which is sign set with full-scale magnitude.
- R7: A sample presented with `smp_valid` is written into the staging register of channel `smp_chan`. At each `frame_tick`, the current value moves to previous and the staged value moves to current. A channel with no new sample in a frame reuses its staged value. A sample presented in the same cycle as `frame_tick` belongs to the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse at each input frame boundary |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_chan | input | CH_W | Channel index of the presented sample |
| smp_data | input | 18 | Two's complement input sample |
| dac_codes | output | NCH·14 | Sign-magnitude converter codes, one 14-bit field per channel |
| os_tick | output | 1 | One-cycle strobe at the four-times rate, marking fresh codes |

## Verification
The group of four results for a frame is due at fixed offsets from the `frame_tick` cycle. The first is due NCH+1 cycles after it: one register stage starts the channel sweep, NCH cycles step through the channels, and one register stage raises the strobe. Each later phase follows a further floor(P/4) cycles, where P is the period just measured. For each expected result, the driver stores the absolute cycle at which it is due, computed from its own count of clocks between frame strobes. The monitor samples half a cycle away from the clock edge and compares both the cycle in which `os_tick` appears and the full code vector against the oldest stored entry. A strobe that comes early, late or unannounced is reported, as is an entry whose due cycle passes without a strobe. Runs with frame periods of 64, 66 and 128 clocks test the rounding down of the quarter period. Input frames held at positive full scale and at negative full scale test the clip and the sign-magnitude extremes.

// File: rtl/os4_pkg.sv
package os4_pkg;
  localparam int unsigned SMP_W  = 18;
  localparam int unsigned CODE_W = 14;
  localparam int unsigned ERR_W  = SMP_W - CODE_W;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [CODE_W-1:0] q_t;
  typedef logic [CODE_W-1:0]        sm_t;
  typedef logic [ERR_W-1:0]         err_t;

  typedef struct packed {
    logic sat;
    q_t   q;
    err_t e;
  } shape_t;

  localparam logic signed [SMP_W:0] SUM_MAX = {2'b00, {(SMP_W-1){1'b1}}};
  localparam smp_t SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};

  // R3: weighted blend of two neighbouring frames, round half up
  function automatic smp_t lin_interp(smp_t a, smp_t b, logic [1:0] ph);
    logic signed [SMP_W+2:0] ea, eb, wa, wb, acc;
    ea  = {{3{a[SMP_W-1]}}, a};
    eb  = {{3{b[SMP_W-1]}}, b};
    wa  = {{SMP_W{1'b0}}, 3'd4 - {1'b0, ph}};
    wb  = {{(SMP_W+1){1'b0}}, ph};
    acc = ea * wa + eb * wb + (SMP_W+3)'(2);
    return acc[SMP_W+1:2];
  endfunction

  // R4/R5: error feedback, clip, truncate
  function automatic shape_t noise_shape(smp_t y, err_t e);
    logic signed [SMP_W:0] v;
    smp_t   vs;
    shape_t r;
    v     = $signed({y[SMP_W-1], y}) + $signed({{(SMP_W+1-ERR_W){1'b0}}, e});
    r.sat = (v > SUM_MAX);
    vs    = r.sat ? SMP_MAX : v[SMP_W-1:0];
    r.q   = vs[SMP_W-1:ERR_W];
    r.e   = vs[ERR_W-1:0];
    return r;
  endfunction

  // R6: two's complement to sign-magnitude, no negative zero
  function automatic sm_t encode_sm(q_t q);
    q_t neg;
    neg = -q;
    if (!q[CODE_W-1])
      return {1'b0, q[CODE_W-2:0]};
    else if (q == {1'b1, {(CODE_W-1){1'b0}}})
      return {1'b1, {(CODE_W-1){1'b1}}};
    else
      return {1'b1, neg[CODE_W-2:0]};
  endfunction
endpackage

// File: rtl/os4_rate_gen.sv
module os4_rate_gen #(
  parameter int unsigned PER_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  output logic       ev,
  output logic [1:0] ev_phase,
  output logic       locked
);
  logic [PER_W-1:0] cnt_q, quarter_q, sub_q;
  logic             seen_q, run_q;
  logic [1:0]       ph_q;
  logic             last_sub, tick_ev, step_ev;

  assign last_sub = (sub_q == quarter_q - 1'b1);
  assign tick_ev  = frame_tick && seen_q;
  assign step_ev  = !frame_tick && run_q && last_sub && (ph_q != 2'd3);
  assign ev       = tick_ev || step_ev;
  assign ev_phase = tick_ev ? 2'd0 : ph_q + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      quarter_q <= '0;
      sub_q     <= '0;
      seen_q    <= 1'b0;
      run_q     <= 1'b0;
      ph_q      <= 2'd0;
      locked    <= 1'b0;
    end else if (frame_tick) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
      if (seen_q) begin
        quarter_q <= (cnt_q + 1'b1) >> 2;
        locked    <= 1'b1;
        run_q     <= 1'b1;
        sub_q     <= '0;
        ph_q      <= 2'd0;
      end
    end else begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (run_q) begin
        if (last_sub) begin
          sub_q <= '0;
          if (ph_q == 2'd3) run_q <= 1'b0;
          else              ph_q  <= ph_q + 2'd1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/os4_chan_store.sv
module os4_chan_store import os4_pkg::*; #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_tick,
  input  logic            smp_valid,
  input  logic [CH_W-1:0] smp_chan,
  input  smp_t            smp_data,
  input  logic [CH_W-1:0] rd_ch,
  output smp_t            rd_prev,
  output smp_t            rd_cur
);
  logic [NCH*SMP_W-1:0] prv_flat, cur_flat;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    smp_t stage_q, prv_q, cur_q;
    // R7: staging, then current, then previous
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q <= '0;
        prv_q   <= '0;
        cur_q   <= '0;
      end else begin
        if (frame_tick) begin
          prv_q <= cur_q;
          cur_q <= stage_q;
        end
        if (smp_valid && smp_chan == CH_W'(k)) stage_q <= smp_data;
      end
    end
    assign prv_flat[k*SMP_W +: SMP_W] = prv_q;
    assign cur_flat[k*SMP_W +: SMP_W] = cur_q;
  end

  assign rd_prev = prv_flat[rd_ch*SMP_W +: SMP_W];
  assign rd_cur  = cur_flat[rd_ch*SMP_W +: SMP_W];
endmodule

// File: rtl/os4_shaper_path.sv
module os4_shaper_path import os4_pkg::*; #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned CH_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev,
  input  logic [1:0]            ev_phase,
  input  smp_t                  prev_s,
  input  smp_t                  cur_s,
  output logic [CH_W-1:0]       rd_ch,
  output logic [NCH*CODE_W-1:0] codes,
  output logic                  os_tick,
  output smp_t                  y_o,
  output logic                  sat_o,
  output sm_t                   wr_code_o,
  output logic                  step_o,
  output logic                  last_o
);
  logic              busy_q;
  logic [CH_W-1:0]   ch_q;
  logic [1:0]        sph_q;
  logic [NCH*ERR_W-1:0] err_flat;
  smp_t   y;
  shape_t sh;
  sm_t    code;

  assign rd_ch  = ch_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (ch_q == CH_W'(NCH-1));

  always_comb begin
    y    = lin_interp(prev_s, cur_s, sph_q);
    sh   = noise_shape(y, err_flat[ch_q*ERR_W +: ERR_W]);
    code = encode_sm(sh.q);
  end

  assign y_o       = y;
  assign sat_o     = busy_q && sh.sat;
  assign wr_code_o = code;

  // one channel per cycle after each event
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ch_q    <= '0;
      sph_q   <= 2'd0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= last_o;
      if (ev) begin
        busy_q <= 1'b1;
        ch_q   <= '0;
        sph_q  <= ev_phase;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        ch_q   <= ch_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_out
    err_t err_q;
    sm_t  code_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_q  <= '0;
        code_q <= '0;
      end else if (busy_q && ch_q == CH_W'(k)) begin
        err_q  <= sh.e;
        code_q <= code;
      end
    end
    assign err_flat[k*ERR_W +: ERR_W]  = err_q;
    assign codes[k*CODE_W +: CODE_W]   = code_q;
  end
endmodule

// File: rtl/os4_shaper.sv
module os4_shaper import os4_pkg::*; #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned PER_W = 16,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_tick,
  input  logic                   smp_valid,
  input  logic [CH_W-1:0]        smp_chan,
  input  logic signed [SMP_W-1:0] smp_data,
  output logic [NCH*CODE_W-1:0]  dac_codes,
  output logic                   os_tick
);
  logic            ev_w, lock_w, sat_w, step_w, sw_last_w;
  logic [1:0]      ev_ph_w;
  logic [CH_W-1:0] rd_ch_w;
  smp_t            prev_w, cur_w, y_w;
  sm_t             wr_code_w;

  os4_rate_gen #(.PER_W(PER_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .ev(ev_w), .ev_phase(ev_ph_w), .locked(lock_w)
  );

  os4_chan_store #(.NCH(NCH), .CH_W(CH_W)) u_store (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .rd_ch(rd_ch_w), .rd_prev(prev_w), .rd_cur(cur_w)
  );

  os4_shaper_path #(.NCH(NCH), .CH_W(CH_W)) u_path (
    .clk(clk), .rst_n(rst_n), .ev(ev_w), .ev_phase(ev_ph_w),
    .prev_s(prev_w), .cur_s(cur_w), .rd_ch(rd_ch_w),
    .codes(dac_codes), .os_tick(os_tick),
    .y_o(y_w), .sat_o(sat_w), .wr_code_o(wr_code_w),
    .step_o(step_w), .last_o(sw_last_w)
  );
endmodule

// File: rtl/os4_shaper_chk.sv
module os4_shaper_chk import os4_pkg::*; #(
  parameter int unsigned NCH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  os_tick,
  input logic [NCH*CODE_W-1:0] dac_codes,
  input logic                  lock_w,
  input logic                  sat_w,
  input logic                  step_w,
  input logic                  sw_last_w,
  input smp_t                  y_w,
  input smp_t                  prev_w,
  input smp_t                  cur_w,
  input sm_t                   wr_code_w
);
  // R1
  a_r1_silent_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_w |-> (!os_tick && dac_codes == '0));

  // R2
  a_r2_single_cycle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);

  // R2
  a_r2_tick_follows_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(os_tick) |-> $past(sw_last_w));

  // R3
  a_r3_between_neighbours: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |-> ((y_w >= prev_w && y_w <= cur_w) || (y_w <= prev_w && y_w >= cur_w)));

  // R5
  a_r5_clip_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    sat_w |-> (wr_code_w == {1'b0, {(CODE_W-1){1'b1}}}));

  // R6
  a_r6_no_negative_zero: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |-> !(wr_code_w[CODE_W-1] && wr_code_w[CODE_W-2:0] == '0));
endmodule

bind os4_shaper os4_shaper_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .dac_codes(dac_codes),
  .lock_w(lock_w), .sat_w(sat_w), .step_w(step_w), .sw_last_w(sw_last_w),
  .y_w(y_w), .prev_w(prev_w), .cur_w(cur_w), .wr_code_w(wr_code_w)
);

// File: tb/sim_os4_shaper.sv
module sim_os4_shaper;
  localparam int NCH = 4;
  localparam int CW  = 14;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 frame_tick = 1'b0;
  logic                 smp_valid = 1'b0;
  logic [1:0]           smp_chan = '0;
  logic signed [17:0]   smp_data = '0;
  logic [NCH*CW-1:0]    dac_codes;
  logic                 os_tick;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int              q_due[$];
  logic [NCH*CW-1:0] q_code[$];
  string           q_tag[$];

  int  m_stage[NCH];
  int  m_prev[NCH];
  int  m_cur[NCH];
  int  m_err[NCH];
  int  last_tick = -1;

  os4_shaper #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .dac_codes(dac_codes), .os_tick(os_tick)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench restatement: weighted step from prev toward cur
  function automatic int m_interp(int a, int b, int k);
    int t;
    t = (b - a) * k + 2;
    return a + (t >>> 2);
  endfunction

  function automatic logic [CW-1:0] m_code(int q);
    int mag;
    if (q >= 0) return CW'(q);
    mag = -q;
    if (mag > 8191) mag = 8191;
    return CW'(8192 + mag);
  endfunction

  // model of one frame boundary; pushes the four expected groups
  task automatic model_tick(string tag);
    int period, qtr, y, v, qv;
    logic [NCH*CW-1:0] vec;
    for (int c = 0; c < NCH; c++) begin
      m_prev[c] = m_cur[c];
      m_cur[c]  = m_stage[c];
    end
    if (last_tick >= 0) begin
      period = cyc - last_tick;
      qtr    = period / 4;
      for (int k = 0; k < 4; k++) begin
        vec = '0;
        for (int c = 0; c < NCH; c++) begin
          y = m_interp(m_prev[c], m_cur[c], k);
          v = y + m_err[c];
          if (v > 131071) v = 131071;
          qv = v >>> 4;
          m_err[c] = v - qv * 16;
          vec[c*CW +: CW] = m_code(qv);
        end
        q_due.push_back(cyc + NCH + 1 + k * qtr);
        q_code.push_back(vec);
        q_tag.push_back(tag);
      end
    end
    last_tick = cyc;
  endtask

  task automatic frame(int plen, int v0, int v1, int v2, int v3, logic [3:0] mask,
                       string tag, bit tsmp, int tch, int tval);
    int vals[4];
    int used;
    vals[0] = v0; vals[1] = v1; vals[2] = v2; vals[3] = v3;
    used = 0;
    frame_tick = 1'b1;
    if (tsmp) begin
      smp_valid = 1'b1;
      smp_chan  = 2'(tch);
      smp_data  = 18'(tval);
    end
    model_tick(tag);
    if (tsmp) m_stage[tch] = tval;
    @(negedge clk);
    frame_tick = 1'b0;
    smp_valid  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        smp_valid = 1'b1;
        smp_chan  = 2'(c);
        smp_data  = 18'(vals[c]);
        m_stage[c] = vals[c];
        used++;
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
    repeat (plen - 1 - used) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (q_due.size() > 0 && q_due[0] < cyc) begin
          chk(1'b0, "R2", "strobe missing", 64'(cyc), 64'(q_due[0]));
          void'(q_due.pop_front());
          void'(q_code.pop_front());
          void'(q_tag.pop_front());
        end
        if (os_tick) begin
          if (q_due.size() == 0) begin
            chk(1'b0, "R1", "unexpected os_tick", 64'(cyc), 64'(0));
          end else begin
            int due;
            logic [NCH*CW-1:0] ec;
            string tg;
            due = q_due.pop_front();
            ec  = q_code.pop_front();
            tg  = q_tag.pop_front();
            chk(cyc == due, "R2", "os_tick cycle", 64'(cyc), 64'(due));
            chk(dac_codes == ec, tg, "codes", 64'(dac_codes), 64'(ec));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_stage[c] = 0; m_prev[c] = 0; m_cur[c] = 0; m_err[c] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(dac_codes == '0, "R1", "codes after reset", 64'(dac_codes), 64'(0));
    chk(os_tick == 1'b0, "R1", "os_tick after reset", 64'(os_tick), 64'(0));

    frame(64, 1000, -1000, 0, 131071, 4'hF, "R1", 1'b0, 0, 0);
    // R1: one frame seen, nothing measured yet
    chk(dac_codes == '0, "R1", "codes before second frame_tick", 64'(dac_codes), 64'(0));

    frame(64, 2000, -3001, 7, 131071, 4'hF, "R3", 1'b0, 0, 0);
    frame(64, -17, 5, -131072, 131071, 4'hF, "R4", 1'b0, 0, 0);
    frame(64, -131072, -131072, -131072, 131071, 4'hF, "R3", 1'b0, 0, 0);
    frame(64, -131072, -131072, -131072, 131071, 4'hF, "R4", 1'b0, 0, 0);
    frame(64, 555, 0, 0, 0, 4'b0001, "R6", 1'b0, 0, 0);
    frame(64, 0, 0, 0, 0, 4'b0000, "R7", 1'b1, 1, -4242);
    frame(66, 12345, -12345, 100, -100, 4'hF, "R7", 1'b0, 0, 0);
    frame(128, 131071, 131071, 131071, 131071, 4'hF, "R2", 1'b0, 0, 0);
    frame(128, 131071, 131071, 131071, 131071, 4'hF, "R5", 1'b0, 0, 0);
    frame(128, 0, 0, 0, 0, 4'b0000, "R5", 1'b0, 0, 0);

    repeat (8) @(negedge clk);
    chk(q_due.size() == 0, "R2", "pending strobes at end", 64'(q_due.size()), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule